// File: doc/BRIEF.md
# Blocking FIFO Communication Cell

This block is a single queue-type cell for passing data words between hardware threads. It keeps a small circular buffer and a tag. The tag holds an empty flag, a full flag, a trigger flag, a constant queue-mode flag, the current entry count and the log2 of the buffer depth. Requests arrive one per cycle. Each request carries a view code, a read/write bit, a thread identifier and a write word. The view code selects how the cell is accessed: raw peek/overwrite, tag control, waiting push/pop, or non-waiting push/pop.

A waiting access that cannot proceed is answered with a blocked response, and the requesting thread's bit is set in a 64-bit waiter map. No other state changes. The next push or pop that does not block pulses a wake output that carries the whole waiter map, and the map is then cleared. The thread scheduler outside the cell uses that pulse to retry the stalled threads. Every request gets a registered response one cycle later.

Top module: `fifo_comm_cell`

## Requirements
- R1: After reset the cell is empty with count 0 and trigger 0, full 0, empty 1, and the queue-mode flag reads 1.
- R2: A read in view 1 (tag) returns a 64-bit word with these fields: log2(DEPTH) in bits 31:28, the count in bits 27:18, queue-mode in bit 17, trigger in bit 16, full in bit 1 and empty in bit 0. All other bits are 0.
- R3: A write in view 1 loads trigger from bit 16, full from bit 1 and empty from bit 0 of the write word. When the written empty bit is 1, the count is set to 0. The head position and the stored words are kept.
- R4: A read in view 0 (raw) returns the oldest entry and does not remove it. A write in view 0 replaces the newest entry when the count is above 0. With a count of 0 it changes nothing.
- R5: A pop (read in view 2 or 3) that does not block clears full. It returns the oldest entry and removes it when the count is above 0, and returns 0 otherwise. Empty is set whenever the count after the access is 0.
- R6: A push (write in view 2 or 3) that does not block clears empty. It appends the word when the count is below DEPTH and drops the word otherwise. Full is set whenever the count after the access equals DEPTH.
- R7: A read in view 2 while empty is 1 clears full, sets the requester's bit in the waiter map and returns blocked with data 0. It changes nothing else.
- R8: A write in view 2 while full is 1 clears empty, sets the requester's bit in the waiter map and returns blocked. It stores nothing.
- R9: A view 2 or 3 access that does not block, made while the waiter map is non-zero, raises wake_valid for one cycle in the response cycle. wake_mask then equals the map before the access, and the map is cleared.
- R10: A view 3 access never returns blocked, even when it has no effect.
- R11: Views 4 and 5 return 0, never block and change nothing. Views 6 and 7 return all ones and change nothing.
- R12: rsp_valid is high in exactly the cycle after each request. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, deasserted in step with clk |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | Access view code (0 raw, 1 tag, 2 waiting, 3 non-waiting, 4/5 counter, 6/7 unused) |
| req_tid | input | TID_W (6) | Requesting thread identifier |
| req_wdata | input | DW (64) | Write word |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW (64) | Read result |
| rsp_blocked | output | 1 | Request was refused and the thread recorded |
| wake_valid | output | 1 | Waiter map released this cycle |
| wake_mask | output | 2**TID_W (64) | Threads to resume |

## Verification
The assertions assume that req_valid, req_write, req_view and req_tid are never unknown once reset is released. The bench drives every input at the falling edge and holds it to known values from time zero. The assertions also assume that the thread scheduler may send a request from a thread that is already recorded, which the stimulus does on purpose by drawing identifiers from a small set.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [2:0] {
    VIEW_RAW     = 3'd0,
    VIEW_TAG     = 3'd1,
    VIEW_Q_WAIT  = 3'd2,
    VIEW_Q_TRY   = 3'd3,
    VIEW_CNT_W   = 3'd4,
    VIEW_CNT_T   = 3'd5,
    VIEW_RSV_A   = 3'd6,
    VIEW_RSV_B   = 3'd7
  } view_e;

  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_DEPTH_W   = 4;
  localparam int TAG_CNT_LSB   = 18;
  localparam int TAG_CNT_W     = 10;
  localparam int TAG_MODE_BIT  = 17;
  localparam int TAG_TRIG_BIT  = 16;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_EMPTY_BIT = 0;

  typedef struct packed {
    logic trig;
    logic full;
    logic empty;
  } flags_t;

endpackage

// File: rtl/fcc_store.sv
module fcc_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] word_q;
    logic          word_en;

    assign word_en = wr_en && (wr_idx == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= wr_data;
      end
    end

    assign ent[g] = word_q;
  end

  assign rd_data = ent[rd_idx];

endmodule

// File: rtl/fcc_waitlist.sv
module fcc_waitlist #(
  parameter int TID_W   = 6,
  localparam int THREADS = 1 << TID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_en,
  input  logic [TID_W-1:0]   rec_tid,
  input  logic               wake_en,
  output logic               wake_valid,
  output logic [THREADS-1:0] wake_mask
);

  logic [THREADS-1:0] map_q, map_d;
  logic               fire_d;
  logic               map_en;

  always_comb begin
    map_d  = map_q;
    fire_d = 1'b0;
    if (wake_en && (map_q != '0)) begin
      map_d  = '0;
      fire_d = 1'b1;
    end else if (rec_en) begin
      map_d[rec_tid] = 1'b1;
    end
  end

  assign map_en = wake_en | rec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
    end else if (map_en) begin
      map_q <= map_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      wake_valid <= fire_d;
      wake_mask  <= fire_d ? map_q : '0;
    end
  end

endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import fcc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  parameter int TID_W = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  view_e            req_view,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    head_word,
  output logic [AW-1:0]    head_idx,
  output logic             st_wr_en,
  output logic [AW-1:0]    st_wr_idx,
  output logic [DW-1:0]    st_wr_data,
  output logic             rec_en,
  output logic             wake_en,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_blocked
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] head_q, head_d;
  logic [CW-1:0] cnt_q, cnt_d;
  flags_t        flg_q, flg_d;
  logic [DW-1:0] rdata_d;
  logic          blk_d;
  logic [DW-1:0] tag_word;
  logic          waiting;

  always_comb begin
    tag_word = '0;
    tag_word[TAG_DEPTH_LSB +: TAG_DEPTH_W] = TAG_DEPTH_W'(AW);
    tag_word[TAG_CNT_LSB +: TAG_CNT_W]     = TAG_CNT_W'(cnt_q);
    tag_word[TAG_MODE_BIT]                 = 1'b1;
    tag_word[TAG_TRIG_BIT]                 = flg_q.trig;
    tag_word[TAG_FULL_BIT]                 = flg_q.full;
    tag_word[TAG_EMPTY_BIT]                = flg_q.empty;
  end

  assign waiting = (req_view == VIEW_Q_WAIT);

  always_comb begin
    head_d     = head_q;
    cnt_d      = cnt_q;
    flg_d      = flg_q;
    rdata_d    = '0;
    blk_d      = 1'b0;
    st_wr_en   = 1'b0;
    st_wr_idx  = head_q;
    st_wr_data = req_wdata;
    rec_en     = 1'b0;
    wake_en    = 1'b0;
    if (req_valid) begin
      unique case (req_view)
        VIEW_RAW: begin
          if (req_write) begin
            if (cnt_q != '0) begin
              st_wr_en  = 1'b1;
              st_wr_idx = head_q + cnt_q[AW-1:0] - AW'(1);
            end
          end else begin
            rdata_d = head_word;
          end
        end
        VIEW_TAG: begin
          if (req_write) begin
            flg_d.trig  = req_wdata[TAG_TRIG_BIT];
            flg_d.full  = req_wdata[TAG_FULL_BIT];
            flg_d.empty = req_wdata[TAG_EMPTY_BIT];
            if (req_wdata[TAG_EMPTY_BIT]) begin
              cnt_d = '0;
            end
          end else begin
            rdata_d = tag_word;
          end
        end
        VIEW_Q_WAIT, VIEW_Q_TRY: begin
          if (!req_write) begin
            flg_d.full = 1'b0;
            if (waiting && flg_q.empty) begin
              rec_en = 1'b1;
              blk_d  = 1'b1;
            end else begin
              wake_en = 1'b1;
              if (cnt_q != '0) begin
                rdata_d = head_word;
                head_d  = head_q + AW'(1);
                cnt_d   = cnt_q - CW'(1);
              end
              if (cnt_d == '0) begin
                flg_d.empty = 1'b1;
              end
            end
          end else begin
            flg_d.empty = 1'b0;
            if (waiting && flg_q.full) begin
              rec_en = 1'b1;
              blk_d  = 1'b1;
            end else begin
              wake_en = 1'b1;
              if (cnt_q < FULL_CNT) begin
                st_wr_en  = 1'b1;
                st_wr_idx = head_q + cnt_q[AW-1:0];
                cnt_d     = cnt_q + CW'(1);
              end
              if (cnt_d == FULL_CNT) begin
                flg_d.full = 1'b1;
              end
            end
          end
        end
        VIEW_CNT_W, VIEW_CNT_T: begin
          rdata_d = '0;
        end
        default: begin
          rdata_d = req_write ? '0 : '1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      flg_q  <= '{trig: 1'b0, full: 1'b0, empty: 1'b1};
    end else if (req_valid) begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
      flg_q  <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_blocked <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= rdata_d;
      rsp_blocked <= blk_d;
    end
  end

  assign head_idx = head_q;

endmodule

// File: rtl/fifo_comm_cell.sv
module fifo_comm_cell #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  parameter int TID_W = 6,
  localparam int AW      = $clog2(DEPTH),
  localparam int THREADS = 1 << TID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [2:0]         req_view,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_blocked,
  output logic               wake_valid,
  output logic [THREADS-1:0] wake_mask
);

  logic [AW-1:0] head_idx;
  logic [DW-1:0] head_word;
  logic          st_wr_en;
  logic [AW-1:0] st_wr_idx;
  logic [DW-1:0] st_wr_data;
  logic          rec_en;
  logic          wake_en;

  fcc_ctrl #(.DEPTH(DEPTH), .DW(DW), .TID_W(TID_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_view   (fcc_pkg::view_e'(req_view)),
    .req_wdata  (req_wdata),
    .head_word  (head_word),
    .head_idx   (head_idx),
    .st_wr_en   (st_wr_en),
    .st_wr_idx  (st_wr_idx),
    .st_wr_data (st_wr_data),
    .rec_en     (rec_en),
    .wake_en    (wake_en),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_blocked(rsp_blocked)
  );

  fcc_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (st_wr_en),
    .wr_idx (st_wr_idx),
    .wr_data(st_wr_data),
    .rd_idx (head_idx),
    .rd_data(head_word)
  );

  fcc_waitlist #(.TID_W(TID_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_en    (rec_en),
    .rec_tid   (req_tid),
    .wake_en   (wake_en),
    .wake_valid(wake_valid),
    .wake_mask (wake_mask)
  );

endmodule

// File: rtl/fifo_comm_cell_chk.sv
module fifo_comm_cell_chk #(
  parameter int DW      = 64,
  parameter int THREADS = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [2:0]         req_view,
  input logic               rsp_valid,
  input logic [DW-1:0]      rsp_rdata,
  input logic               rsp_blocked,
  input logic               wake_valid,
  input logic [THREADS-1:0] wake_mask
);

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R10
  only_wait_view_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view != 3'd2) |=> !rsp_blocked);

  // R7
  blocked_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> (rsp_rdata == '0 && rsp_valid));

  // R9
  wake_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (wake_mask != '0 && !rsp_blocked));

  // R9
  wake_from_queue_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_view != 3'd2) && (req_view != 3'd3)) |=> !wake_valid);

  // R11
  unused_view_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_view[2:1] == 2'b11) |=> (rsp_rdata == '1));

endmodule

bind fifo_comm_cell fifo_comm_cell_chk #(.DW(DW), .THREADS(THREADS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_view   (req_view),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_blocked(rsp_blocked),
  .wake_valid (wake_valid),
  .wake_mask  (wake_mask)
);

// File: tb/tb_fifo_comm_cell.sv
module tb_fifo_comm_cell;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int LD = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [2:0]  req_view;
  logic [5:0]  req_tid;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_blocked;
  logic        wake_valid;
  logic [63:0] wake_mask;

  int n_vec;
  int n_bad;
  bit done;

  logic [63:0] m_data [D];
  int          m_head;
  int          m_cnt;
  bit          m_e, m_f, m_t;
  logic [63:0] m_map;

  fifo_comm_cell #(.DEPTH(D), .DW(64), .TID_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_blocked(rsp_blocked),
    .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model_reset();
    for (int i = 0; i < D; i++) m_data[i] = '0;
    m_head = 0; m_cnt = 0; m_e = 1; m_f = 0; m_t = 0; m_map = '0;
  endtask

  function automatic logic [63:0] tag_word();
    return (64'(LD) << 28) | (64'(m_cnt) << 18) | (64'(1) << 17) |
           (64'(m_t) << 16) | (64'(m_f) << 1) | 64'(m_e);
  endfunction

  // Expected response for one request, updating the model.
  task automatic model_step(input bit wr, input int view, input int tid,
                            input logic [63:0] wd,
                            output logic [63:0] rd, output bit blk,
                            output bit wv, output logic [63:0] wm,
                            output string tag);
    bit wt;
    rd = '0; blk = 0; wv = 0; wm = '0; tag = "R11";
    wt = (view == 2);
    case (view)
      0: begin
        tag = "R4";
        if (wr) begin
          if (m_cnt > 0) m_data[(m_head + m_cnt - 1) % D] = wd;
        end else rd = m_data[m_head];
      end
      1: begin
        if (wr) begin
          tag = "R3";
          m_t = wd[16]; m_f = wd[1]; m_e = wd[0];
          if (m_e) m_cnt = 0;
        end else begin
          tag = "R2";
          rd = tag_word();
        end
      end
      2, 3: begin
        if (!wr) begin
          tag = wt ? "R5" : "R10";
          m_f = 0;
          if (wt && m_e) begin
            m_map[tid] = 1'b1; blk = 1; tag = "R7";
          end else begin
            if (m_map != '0) begin wv = 1; wm = m_map; m_map = '0; tag = "R9"; end
            if (m_cnt > 0) begin
              rd = m_data[m_head]; m_head = (m_head + 1) % D; m_cnt--;
            end
            if (m_cnt == 0) m_e = 1;
          end
        end else begin
          tag = wt ? "R6" : "R10";
          m_e = 0;
          if (wt && m_f) begin
            m_map[tid] = 1'b1; blk = 1; tag = "R8";
          end else begin
            if (m_map != '0) begin wv = 1; wm = m_map; m_map = '0; tag = "R9"; end
            if (m_cnt < D) begin
              m_data[(m_head + m_cnt) % D] = wd; m_cnt++;
            end
            if (m_cnt == D) m_f = 1;
          end
        end
      end
      4, 5: rd = '0;
      default: rd = wr ? '0 : '1;
    endcase
  endtask

  task automatic apply(input bit wr, input int view, input int tid,
                       input logic [63:0] wd);
    logic [63:0] e_rd, e_wm;
    bit          e_blk, e_wv;
    string       tag;
    model_step(wr, view, tid, wd, e_rd, e_blk, e_wv, e_wm, tag);
    req_valid = 1'b1; req_write = wr; req_view = 3'(view);
    req_tid = 6'(tid); req_wdata = wd;
    @(negedge clk);
    n_vec++;
    if (rsp_valid !== 1'b1 || rsp_rdata !== e_rd || rsp_blocked !== e_blk ||
        wake_valid !== e_wv || wake_mask !== e_wm) begin
      n_bad++;
      $display("FAIL %s (R12) view=%0d wr=%0b: got v=%b d=%h b=%b w=%b m=%h exp v=1 d=%h b=%b w=%b m=%h",
               tag, view, wr, rsp_valid, rsp_rdata, rsp_blocked, wake_valid, wake_mask,
               e_rd, e_blk, e_wv, e_wm);
    end
    req_valid = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    n_vec++;
    if (rsp_valid !== 1'b0 || wake_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 idle: got v=%b w=%b exp v=0 w=0", rsp_valid, wake_valid);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    n_vec = 0; n_bad = 0; done = 0;
    req_valid = 0; req_write = 0; req_view = '0; req_tid = '0; req_wdata = '0;
    rst_n = 1'b0;
    model_reset();
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_check();                          // R12 no response without request
    apply(0, 1, 0, '0);                    // R1 reset tag word
    apply(0, 2, 5, '0);                    // R7 blocked pop on empty
    apply(0, 3, 9, '0);                    // R10 try pop on empty
    for (int i = 0; i < D; i++) apply(1, 3, 1, 64'hA000 + 64'(i)); // R6, R9 first
    apply(1, 3, 2, 64'hDEAD);              // R6 full, dropped
    apply(1, 2, 7, 64'hBEEF);              // R8 blocked push
    apply(1, 2, 63, 64'hBEEF);             // R8 second waiter
    apply(0, 1, 0, '0);                    // R2 count 8, full
    apply(0, 0, 0, '0);                    // R4 peek
    apply(1, 0, 0, 64'h1234_5678);         // R4 overwrite newest
    apply(0, 2, 3, '0);                    // R9 wake and pop
    for (int i = 0; i < D; i++) apply(0, 3, 4, '0); // R5 drain to zero
    apply(1, 0, 0, 64'h5555);              // R4 ignored at count 0
    apply(0, 0, 0, '0);                    // R4 peek after ignored write
    apply(1, 4, 0, 64'h1);                 // R11
    apply(0, 5, 0, '0);                    // R11
    apply(0, 6, 0, '0);                    // R11
    apply(1, 7, 0, 64'h9);                 // R11
    apply(1, 1, 0, 64'h1_0002);            // R3 trig, full, not empty
    apply(0, 1, 0, '0);                    // R3 readback
    apply(1, 3, 0, 64'h77);                // R6 push past full flag
    apply(1, 1, 0, 64'h1);                 // R3 empty clears count
    apply(0, 1, 0, '0);                    // R3 readback
    idle_check();                          // R12
    for (int n = 0; n < 4000; n++) begin
      int r, view;
      bit wr;
      r = $urandom_range(0, 19);
      if (r < 6) view = 2;
      else if (r < 12) view = 3;
      else if (r < 14) view = 0;
      else if (r < 16) view = 1;
      else view = $urandom_range(4, 7);
      wr = $urandom_range(0, 1) == 1;
      if (view == 1 && wr && $urandom_range(0, 3) != 0) begin
        apply(1, 1, 0, {$urandom(), $urandom()} & 64'hFFFF_FFFF_FFFE_FFFE);
      end else begin
        apply(wr, view, $urandom_range(0, 63) & 6'h0F, {$urandom(), $urandom()});
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule